// File: doc/BRIEF.md
# Entropy Seed CSR Privilege Gate

This block decides whether a CSR instruction aimed at the entropy seed register may go ahead. The seed register is unprivileged. It must work in a hart that has only machine mode, and also in a hart with user, supervisor and hypervisor-guest modes. The gate holds two machine-owned enable bits in a small configuration register: one lets the host supervisor reach the seed, and one lets host user code reach it.

For each request, the caller presents the following:
- the current privilege level;
- the virtualization flag;
- the CSR function code;
- the source field (the rs1 index or the 5-bit immediate).

One cycle later the gate gives a registered verdict with a valid strobe: grant, illegal-instruction, or virtual-instruction. It also gives the exception cause code that goes with the verdict.

Guest supervisor and guest user code never get the seed. Which exception a guest sees depends only on the kind of access and on the supervisor enable bit. The trap sequencing and the entropy generator sit outside this block.

The verdict register is a four-state machine:
- `VERDICT_NONE` is the idle state.
- `VERDICT_GRANT`, `VERDICT_ILLEGAL` and `VERDICT_VIRTUAL` each hold a decided result for one cycle.

Every state moves to the decided verdict when a request is present. Every state moves to `VERDICT_NONE` when no request is present. Reset enters `VERDICT_NONE`.

Top module: `seed_access_gate`

## Requirements
- R1: A request sampled at a rising edge produces `rsp_valid` high after the next edge, for exactly one cycle per request. While valid, exactly one of `rsp_grant`, `rsp_illegal` and `rsp_virtual` is high. With no request, `rsp_valid` and all three flags are low.
- R2: The access kind is decoded from the function code `req_op`.
  - 3'b001 and 3'b101 (swap forms) always write.
  - 3'b010, 3'b011, 3'b110 and 3'b111 (set/clear forms) write only when `req_src` is nonzero.
  - 3'b000 and 3'b100 never write.
- R3: An access that does not write gives illegal-instruction at every privilege level, machine mode included.
- R4: A writing access at machine level (`req_priv` = 2'b11) is granted whatever the enable bits hold and whatever `req_virt` holds.
- R5: A writing access at host supervisor level (`req_priv` = 2'b01, `req_virt` = 0) is granted when the supervisor enable bit is 1. Otherwise it gives illegal-instruction.
- R6: A writing access at host user level (`req_priv` = 2'b00, `req_virt` = 0) is granted when the user enable bit is 1. Otherwise it gives illegal-instruction.
- R7: Guest supervisor and guest user accesses (`req_virt` = 1, `req_priv` of 2'b01 or 2'b00) are never granted.
  - A writing guest access gives virtual-instruction when the supervisor enable bit is 1, and illegal-instruction when it is 0.
  - The user enable bit never changes a guest outcome.
- R8: The cause codes are fixed.
  - `rsp_cause` is 2 with illegal-instruction.
  - `rsp_cause` is 22 with virtual-instruction.
  - `rsp_cause` is 0 with a grant.
  - The reserved level 2'b10 always gives illegal-instruction.
- R9: Both enable bits reset to 0.
  - A configuration write at machine level loads `cfg_wr_sen`/`cfg_wr_uen`, visible on `cfg_sen`/`cfg_uen` after the next edge.
  - A configuration write at any other level leaves both bits unchanged and pulses `cfg_wr_illegal` for one cycle after the edge.
- R10: With parameter `HAS_CFG` = 0, both enable bits read as 0 permanently. Machine-level writes have no effect, so only machine mode can ever be granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CSR request to the seed address this cycle |
| req_priv | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Hart is running a guest |
| req_op | input | 3 | CSR function code |
| req_src | input | SRC_W | rs1 index or immediate of the request |
| cfg_wr_valid | input | 1 | Write to the enable configuration register |
| cfg_wr_priv | input | 2 | Privilege level of the configuration write |
| cfg_wr_sen | input | 1 | New supervisor enable value |
| cfg_wr_uen | input | 1 | New user enable value |
| rsp_valid | output | 1 | Verdict valid strobe |
| rsp_grant | output | 1 | Access granted |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_virtual | output | 1 | Virtual-instruction exception |
| rsp_cause | output | CAUSE_W | Exception cause code |
| cfg_wr_illegal | output | 1 | Rejected configuration write |
| cfg_sen | output | 1 | Current supervisor enable bit |
| cfg_uen | output | 1 | Current user enable bit |

## Verification
The assertions check three things on every cycle:
- the strobe timing and the one-hot verdict;
- that non-writing accesses and guest accesses are never granted, and that machine-level writes always are;
- that each cause code matches its flag, and that configuration writes from a lower level change nothing.

The exact mapping of every combination of level, guest flag, function code, source value and enable pair onto a verdict comes only from the bench's sweep, which checks it against an independently computed table. Two things appear only in the bench's scenarios: the absence of any effect of the user bit on guest outcomes, and the hardwired-zero variant.

// File: rtl/seed_gate_pkg.sv
package seed_gate_pkg;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = CAUSE_W'(2);
    localparam logic [CAUSE_W-1:0] CAUSE_VIRTUAL = CAUSE_W'(22);
    localparam logic [CAUSE_W-1:0] CAUSE_NONE    = '0;

    typedef enum logic [1:0] {
        PRV_U    = 2'd0,
        PRV_S    = 2'd1,
        PRV_RSVD = 2'd2,
        PRV_M    = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        VERDICT_NONE    = 2'd0,
        VERDICT_GRANT   = 2'd1,
        VERDICT_ILLEGAL = 2'd2,
        VERDICT_VIRTUAL = 2'd3
    } verdict_e;

endpackage

// File: rtl/seed_write_detect.sv
module seed_write_detect #(
    parameter int SRC_W = 5
) (
    input  logic [2:0]       op,
    input  logic [SRC_W-1:0] src,
    output logic             writes
);
    // op[1:0]: 01 swap, 10 set, 11 clear, 00 not a CSR access
    logic src_nonzero;

    always_comb begin
        src_nonzero = |src;
        unique case (op[1:0])
            2'b01:   writes = 1'b1;
            2'b10,
            2'b11:   writes = src_nonzero;
            default: writes = 1'b0;
        endcase
    end
endmodule

// File: rtl/seed_cfg_reg.sv
module seed_cfg_reg
    import seed_gate_pkg::*;
#(
    parameter bit HAS_CFG = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [1:0] wr_priv,
    input  logic       wr_sen,
    input  logic       wr_uen,
    output logic       sen,
    output logic       uen,
    output logic       wr_reject
);
    logic from_machine;
    assign from_machine = (priv_e'(wr_priv) == PRV_M);

    always_ff @(posedge clk) begin
        if (!rst_n) wr_reject <= 1'b0;
        else        wr_reject <= wr_valid && !from_machine;
    end

    generate
        if (HAS_CFG) begin : g_writable
            logic sen_q, uen_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sen_q <= 1'b0;
                    uen_q <= 1'b0;
                end else if (wr_valid && from_machine) begin
                    sen_q <= wr_sen;
                    uen_q <= wr_uen;
                end
            end
            assign sen = sen_q;
            assign uen = uen_q;

            a_r9_machine_load: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && from_machine) |=> (sen == $past(wr_sen) && uen == $past(wr_uen)));
        end else begin : g_fixed
            logic unused_wr;
            assign unused_wr = wr_sen ^ wr_uen;
            assign sen = 1'b0;
            assign uen = 1'b0;
        end
    endgenerate

    a_r9_low_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !from_machine) |=> (wr_reject && $stable(sen) && $stable(uen)));
endmodule

// File: rtl/seed_priv_decide.sv
module seed_priv_decide
    import seed_gate_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       writes,
    input  logic       sen,
    input  logic       uen,
    output verdict_e   verdict
);
    // Guest outcome never depends on the user bit.
    verdict_e guest_verdict;

    always_comb begin
        guest_verdict = sen ? VERDICT_VIRTUAL : VERDICT_ILLEGAL;
        if (!writes) begin
            verdict = VERDICT_ILLEGAL;
        end else begin
            unique case (priv_e'(priv))
                PRV_M:    verdict = VERDICT_GRANT;
                PRV_S:    verdict = virt ? guest_verdict
                                         : (sen ? VERDICT_GRANT : VERDICT_ILLEGAL);
                PRV_U:    verdict = virt ? guest_verdict
                                         : (uen ? VERDICT_GRANT : VERDICT_ILLEGAL);
                PRV_RSVD: verdict = VERDICT_ILLEGAL;
            endcase
        end
    end
endmodule

// File: rtl/seed_access_gate.sv
module seed_access_gate
    import seed_gate_pkg::*;
#(
    parameter int SRC_W   = 5,
    parameter bit HAS_CFG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_priv,
    input  logic               req_virt,
    input  logic [2:0]         req_op,
    input  logic [SRC_W-1:0]   req_src,
    input  logic               cfg_wr_valid,
    input  logic [1:0]         cfg_wr_priv,
    input  logic               cfg_wr_sen,
    input  logic               cfg_wr_uen,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic               rsp_illegal,
    output logic               rsp_virtual,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic               cfg_wr_illegal,
    output logic               cfg_sen,
    output logic               cfg_uen
);
    logic     is_write;
    verdict_e verdict_d;
    verdict_e verdict_q;

    seed_write_detect #(.SRC_W(SRC_W)) u_wdet (
        .op     (req_op),
        .src    (req_src),
        .writes (is_write)
    );

    seed_cfg_reg #(.HAS_CFG(HAS_CFG)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (cfg_wr_valid),
        .wr_priv   (cfg_wr_priv),
        .wr_sen    (cfg_wr_sen),
        .wr_uen    (cfg_wr_uen),
        .sen       (cfg_sen),
        .uen       (cfg_uen),
        .wr_reject (cfg_wr_illegal)
    );

    seed_priv_decide u_decide (
        .priv    (req_priv),
        .virt    (req_virt),
        .writes  (is_write),
        .sen     (cfg_sen),
        .uen     (cfg_uen),
        .verdict (verdict_d)
    );

    // State register: any state -> decided verdict on request, else NONE
    always_ff @(posedge clk) begin
        if (!rst_n)         verdict_q <= VERDICT_NONE;
        else if (req_valid) verdict_q <= verdict_d;
        else                verdict_q <= VERDICT_NONE;
    end

    // Output decode
    always_comb begin
        rsp_valid   = 1'b0;
        rsp_grant   = 1'b0;
        rsp_illegal = 1'b0;
        rsp_virtual = 1'b0;
        rsp_cause   = CAUSE_NONE;
        unique case (verdict_q)
            VERDICT_NONE: ;
            VERDICT_GRANT: begin
                rsp_valid = 1'b1;
                rsp_grant = 1'b1;
            end
            VERDICT_ILLEGAL: begin
                rsp_valid   = 1'b1;
                rsp_illegal = 1'b1;
                rsp_cause   = CAUSE_ILLEGAL;
            end
            VERDICT_VIRTUAL: begin
                rsp_valid   = 1'b1;
                rsp_virtual = 1'b1;
                rsp_cause   = CAUSE_VIRTUAL;
            end
        endcase
    end

    a_r1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r1_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_grant, rsp_illegal, rsp_virtual}) == 1));
    a_r3_read_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_write) |=> rsp_illegal);
    a_r4_machine_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_write && req_priv == 2'b11) |=> rsp_grant);
    a_r7_guest_never: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_virt && req_priv != 2'b11) |=> !rsp_grant);
    a_r8_cause_ill: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (rsp_cause == CAUSE_W'(2)));
    a_r8_cause_virt: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_virtual |-> (rsp_cause == CAUSE_W'(22)));
endmodule

// File: tb/seed_access_gate_tb.sv
`timescale 1ns/1ps
module seed_access_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_priv = '0;
    logic       req_virt = 1'b0;
    logic [2:0] req_op = '0;
    logic [4:0] req_src = '0;
    logic       cfg_wr_valid = 1'b0;
    logic [1:0] cfg_wr_priv = '0;
    logic       cfg_wr_sen = 1'b0;
    logic       cfg_wr_uen = 1'b0;
    logic       rsp_valid, rsp_grant, rsp_illegal, rsp_virtual;
    logic [4:0] rsp_cause;
    logic       cfg_wr_illegal, cfg_sen, cfg_uen;
    logic       f_valid, f_grant, f_illegal, f_virtual, f_wr_illegal, f_sen, f_uen;
    logic [4:0] f_cause;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    seed_access_gate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
        .req_virt(req_virt), .req_op(req_op), .req_src(req_src),
        .cfg_wr_valid(cfg_wr_valid), .cfg_wr_priv(cfg_wr_priv),
        .cfg_wr_sen(cfg_wr_sen), .cfg_wr_uen(cfg_wr_uen),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_illegal(rsp_illegal),
        .rsp_virtual(rsp_virtual), .rsp_cause(rsp_cause),
        .cfg_wr_illegal(cfg_wr_illegal), .cfg_sen(cfg_sen), .cfg_uen(cfg_uen)
    );

    seed_access_gate #(.HAS_CFG(1'b0)) u_dut_fixed (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
        .req_virt(req_virt), .req_op(req_op), .req_src(req_src),
        .cfg_wr_valid(cfg_wr_valid), .cfg_wr_priv(cfg_wr_priv),
        .cfg_wr_sen(cfg_wr_sen), .cfg_wr_uen(cfg_wr_uen),
        .rsp_valid(f_valid), .rsp_grant(f_grant), .rsp_illegal(f_illegal),
        .rsp_virtual(f_virtual), .rsp_cause(f_cause),
        .cfg_wr_illegal(f_wr_illegal), .cfg_sen(f_sen), .cfg_uen(f_uen)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // 0 grant, 1 illegal, 2 virtual
    function automatic int expected_verdict(int priv, bit virt, int op, int src,
                                            bit s, bit u);
        bit wr;
        wr = (op == 1 || op == 5) ||
             ((op == 2 || op == 3 || op == 6 || op == 7) && src != 0);
        if (!wr) return 1;
        if (priv == 3) return 0;
        if (priv == 2) return 1;
        if (virt) return s ? 2 : 1;
        if (priv == 1) return s ? 0 : 1;
        return u ? 0 : 1;
    endfunction

    task automatic cfg_write(input int priv, input bit s, input bit u);
        cfg_wr_valid = 1'b1;
        cfg_wr_priv  = 2'(priv);
        cfg_wr_sen   = s;
        cfg_wr_uen   = u;
        @(negedge clk);
        cfg_wr_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state; R1 idle
        check(cfg_sen == 0 && cfg_uen == 0, "R9", "reset enables", {cfg_sen, cfg_uen}, 0);
        check(rsp_valid == 0, "R1", "idle valid", rsp_valid, 0);

        // R9: write from supervisor and user ignored and flagged
        for (int p = 0; p < 3; p++) begin
            cfg_wr_valid = 1'b1; cfg_wr_priv = 2'(p); cfg_wr_sen = 1; cfg_wr_uen = 1;
            @(negedge clk);
            cfg_wr_valid = 1'b0;
            check(cfg_sen == 0 && cfg_uen == 0, "R9", "low write enables", {cfg_sen, cfg_uen}, 0);
            check(cfg_wr_illegal == 1, "R9", "low write flag", cfg_wr_illegal, 1);
            @(negedge clk);
            check(cfg_wr_illegal == 0, "R9", "flag one cycle", cfg_wr_illegal, 0);
        end

        for (int cfgv = 0; cfgv < 4; cfgv++) begin
            bit s, u;
            s = cfgv[1];
            u = cfgv[0];
            cfg_write(3, s, u);
            check(cfg_sen == s && cfg_uen == u, "R9", "machine write",
                  {cfg_sen, cfg_uen}, {s, u});
            check(cfg_wr_illegal == 0, "R9", "machine write no flag", cfg_wr_illegal, 0);
            check(f_sen == 0 && f_uen == 0, "R10", "fixed enables", {f_sen, f_uen}, 0);
            for (int p = 0; p < 4; p++)
                for (int v = 0; v < 2; v++)
                    for (int op = 0; op < 8; op++)
                        for (int si = 0; si < 2; si++) begin
                            int src, e, a, ec, fe, fa;
                            src = si ? 5 : 0;
                            req_valid = 1'b1; req_priv = 2'(p); req_virt = v[0];
                            req_op = 3'(op); req_src = 5'(src);
                            @(negedge clk);
                            req_valid = 1'b0;
                            e  = expected_verdict(p, v[0], op, src, s, u);
                            a  = rsp_grant ? 0 : rsp_illegal ? 1 : rsp_virtual ? 2 : 3;
                            ec = (e == 1) ? 2 : (e == 2) ? 22 : 0;
                            // R2 R3 R4 R5 R6 R7 verdict table
                            check(rsp_valid && a == e, (e == 2 || (v && p < 2)) ? "R7" :
                                  (p == 3) ? "R4" : (p == 1) ? "R5" : (p == 0) ? "R6" : "R3",
                                  "verdict", a, e);
                            check(rsp_valid && $countones({rsp_grant, rsp_illegal, rsp_virtual}) == 1,
                                  "R1", "one hot", {rsp_grant, rsp_illegal, rsp_virtual}, 0);
                            check(rsp_cause == 5'(ec), "R8", "cause", rsp_cause, ec);
                            fe = expected_verdict(p, v[0], op, src, 0, 0);
                            fa = f_grant ? 0 : f_illegal ? 1 : f_virtual ? 2 : 3;
                            check(f_valid && fa == fe, "R10", "fixed verdict", fa, fe);
                        end
            @(negedge clk);
            check(rsp_valid == 0, "R1", "strobe single cycle", rsp_valid, 0);
        end

        // R7: user bit never alters a guest outcome (s=0, u toggled)
        cfg_write(3, 0, 1);
        req_valid = 1; req_priv = 2'd0; req_virt = 1; req_op = 3'd1; req_src = 0;
        @(negedge clk);
        req_valid = 0;
        check(rsp_illegal == 1, "R7", "guest user with uen", rsp_illegal, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule